// File: doc/BRIEF.md
# DRAM bank command sequencer

This block turns simple memory requests into the command stream of a DRAM device whose row and column addresses share one set of address pins. A request carries a read/write flag, a flat address and write data, and is taken with a ready/valid handshake. For each request the block emits the commands the target bank needs: a precharge to close a row that is in the way, an activate to open the wanted row, and finally a single column read or write.

The block remembers one open row for each bank. A later request to that row goes straight to the column command. A request to a different row in the same bank first closes the open row. A request to a bank with no open row starts with activation. Fixed cycle counts, set by parameters, separate the phases. Read data comes back from the device a fixed number of cycles after the column read and is passed on with a one-cycle valid pulse.

The block serves one request at a time and never reorders requests. Refresh, double-rate data capture and the electrical side of the device are left to other blocks.

Top module: `bank_cmd_seq`

## Requirements
- R1: After reset `req_ready` is 1, `cmd_code` is 0 (no operation), `rd_valid` is 0, and every bank is treated as having no open row.
- R2: `req_addr` is split as {row, bank, column}, with the column in the low COL_W bits and the bank in the next BANK_W bits. Each command is a one-cycle pulse on `cmd_code`, with 0 = none, 1 = activate, 2 = column read, 3 = column write and 4 = precharge. `cmd_bank` carries the bank field. `cmd_addr` carries the row with an activate and the column with a read or write.
- R3: A request to the row that is already open in its bank produces exactly one command: the column read or write.
- R4: A request to a bank whose open row is a different row produces precharge, then activate with the new row, then the column command, all to that bank.
- R5: A request to a bank with no open row produces activate and then the column command, with no precharge.
- R6: An activate comes exactly T_RP cycles after the precharge before it in the same request. A column command comes exactly T_RCD cycles after its activate. No command follows a column command by fewer than T_CCD cycles.
- R7: `req_ready` stays 0 while a request is being served. After the column command it stays 0 for T_CCD-2 more cycles and returns to 1 in the cycle T_CCD-1 after the column command.
- R8: A column write carries the request's write data on `cmd_wdata` in the same cycle. A column read causes a one-cycle `rd_valid` pulse exactly CL cycles after the read command, with `rd_data` equal to `dram_rdata` in that cycle.
- R9: Each bank keeps its own open row, so serving a request in one bank never closes the row open in another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+BANK_W+COL_W | Flat address {row, bank, column} |
| req_wdata | input | DQ_W | Write data |
| cmd_code | output | 3 | Command to the device (0 none, 1 activate, 2 read, 3 write, 4 precharge) |
| cmd_bank | output | BANK_W | Target bank of the command |
| cmd_addr | output | max(ROW_W,COL_W) | Shared row/column address |
| cmd_wdata | output | DQ_W | Write data sent with a column write |
| dram_rdata | input | DQ_W | Read data returned by the device |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DQ_W | Read data to the requester |

## Verification
The hardest case to reach from the ports is a row miss in a bank that already holds another row, while other banks also keep rows open. Only this case needs the full precharge, activate and column sequence while the open-row state of the other banks is left unchanged. The directed tests first open rows in two banks with writes. They then send a read to a new row in one of those banks and a read to the still-open row in the other. A bench-side bank model holds the written data, so a read after a precharge and reactivation must still return the value written before.

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq #(
  parameter int ROW_W  = 4,
  parameter int BANK_W = 2,
  parameter int COL_W  = 4,
  parameter int DQ_W   = 8,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_CCD  = 3,
  parameter int CL     = 3
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      req_valid,
  output logic                                      req_ready,
  input  logic                                      req_write,
  input  logic [ROW_W+BANK_W+COL_W-1:0]             req_addr,
  input  logic [DQ_W-1:0]                           req_wdata,
  output logic [2:0]                                cmd_code,
  output logic [BANK_W-1:0]                         cmd_bank,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] cmd_addr,
  output logic [DQ_W-1:0]                           cmd_wdata,
  input  logic [DQ_W-1:0]                           dram_rdata,
  output logic                                      rd_valid,
  output logic [DQ_W-1:0]                           rd_data
);
  localparam int NB     = 1 << BANK_W;
  localparam int ADDR_W = ROW_W + BANK_W + COL_W;
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TMAX   = (T_RCD > T_RP) ? ((T_RCD > T_CCD) ? T_RCD : T_CCD)
                                         : ((T_RP > T_CCD) ? T_RP : T_CCD);
  localparam int TW     = $clog2(TMAX + 1);

  localparam logic [2:0] C_NOP = 3'd0;
  localparam logic [2:0] C_ACT = 3'd1;
  localparam logic [2:0] C_RD  = 3'd2;
  localparam logic [2:0] C_WR  = 3'd3;
  localparam logic [2:0] C_PRE = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ACT, S_COL} st_t;

  st_t                 state;
  logic [TW-1:0]       timer;
  logic                q_write;
  logic [ROW_W-1:0]    q_row;
  logic [BANK_W-1:0]   q_bank;
  logic [COL_W-1:0]    q_col;
  logic [DQ_W-1:0]     q_wdata;
  logic [NB-1:0]       open_vld;
  logic [ROW_W-1:0]    open_row [NB];
  logic [CL:0]         rd_pipe;

  wire [ROW_W-1:0]  in_row  = req_addr[ADDR_W-1 -: ROW_W];
  wire [BANK_W-1:0] in_bank = req_addr[COL_W +: BANK_W];
  wire [COL_W-1:0]  in_col  = req_addr[COL_W-1:0];
  wire              go      = (timer == '0);
  wire              accept  = req_valid && req_ready;

  assign req_ready = (state == S_IDLE) && go;
  assign rd_valid  = rd_pipe[CL];
  assign rd_data   = dram_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      timer     <= '0;
      q_write   <= 1'b0;
      q_row     <= '0;
      q_bank    <= '0;
      q_col     <= '0;
      q_wdata   <= '0;
      open_vld  <= '0;
      for (int b = 0; b < NB; b++) open_row[b] <= '0;
      rd_pipe   <= '0;
      cmd_code  <= C_NOP;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
    end else begin
      cmd_code  <= C_NOP;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
      rd_pipe   <= {rd_pipe[CL-1:0], 1'b0};
      if (!go) timer <= timer - TW'(1);
      case (state)
        S_IDLE: if (accept) begin
          q_write <= req_write;
          q_row   <= in_row;
          q_bank  <= in_bank;
          q_col   <= in_col;
          q_wdata <= req_wdata;
          if (open_vld[in_bank] && open_row[in_bank] == in_row) state <= S_COL;
          else if (open_vld[in_bank])                           state <= S_PRE;
          else                                                  state <= S_ACT;
        end
        S_PRE: if (go) begin
          cmd_code         <= C_PRE;
          cmd_bank         <= q_bank;
          open_vld[q_bank] <= 1'b0;
          timer            <= TW'(T_RP - 1);
          state            <= S_ACT;
        end
        S_ACT: if (go) begin
          cmd_code         <= C_ACT;
          cmd_bank         <= q_bank;
          cmd_addr         <= MUX_W'(q_row);
          open_vld[q_bank] <= 1'b1;
          open_row[q_bank] <= q_row;
          timer            <= TW'(T_RCD - 1);
          state            <= S_COL;
        end
        S_COL: if (go) begin
          cmd_code   <= q_write ? C_WR : C_RD;
          cmd_bank   <= q_bank;
          cmd_addr   <= MUX_W'(q_col);
          cmd_wdata  <= q_write ? q_wdata : '0;
          rd_pipe[0] <= !q_write;
          timer      <= TW'(T_CCD - 1);
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Shadow of the bank state seen only from the command outputs.
  logic [NB-1:0] sh_open;
  logic [7:0]    gap;
  logic [2:0]    last_cmd;
  logic [7:0]    need;

  always_comb begin
    case (last_cmd)
      C_ACT:       need = 8'(T_RCD);
      C_PRE:       need = 8'(T_RP);
      C_RD, C_WR:  need = 8'(T_CCD);
      default:     need = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_open  <= '0;
      gap      <= '0;
      last_cmd <= C_NOP;
    end else begin
      if (cmd_code == C_ACT) sh_open[cmd_bank] <= 1'b1;
      if (cmd_code == C_PRE) sh_open[cmd_bank] <= 1'b0;
      if (cmd_code != C_NOP) begin
        last_cmd <= cmd_code;
        gap      <= 8'd1;
      end else if (gap != 8'hFF) begin
        gap <= gap + 8'd1;
      end
    end
  end

  assert_act_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_ACT) |-> !sh_open[cmd_bank]);
  assert_pre_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_PRE) |-> sh_open[cmd_bank]);
  assert_col_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_RD || cmd_code == C_WR) |-> sh_open[cmd_bank]);
  assert_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code != C_NOP) |-> (gap >= need));
  assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code <= C_PRE);
endmodule

// File: tb/bank_cmd_seq_tb_top.sv
module bank_cmd_seq_tb_top;
  localparam int ROW_W = 4, BANK_W = 2, COL_W = 4, DQ_W = 8;
  localparam int T_RCD = 3, T_RP = 3, T_CCD = 3, CL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W+BANK_W+COL_W-1:0] req_addr = '0;
  logic [DQ_W-1:0] req_wdata = '0, dram_rdata = '0;
  logic req_ready, rd_valid;
  logic [2:0] cmd_code;
  logic [BANK_W-1:0] cmd_bank;
  logic [3:0] cmd_addr;
  logic [DQ_W-1:0] cmd_wdata, rd_data;

  always #10 clk = ~clk;

  bank_cmd_seq #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .DQ_W(DQ_W),
                 .T_RCD(T_RCD), .T_RP(T_RP), .T_CCD(T_CCD), .CL(CL)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .dram_rdata(dram_rdata), .rd_valid(rd_valid),
    .rd_data(rd_data));

  int n_chk = 0, n_fail = 0, cyc = 0;
  int log_n = 0, rv_n = 0;
  int lg_cyc [256]; int lg_code [256]; int lg_bank [256]; int lg_addr [256]; int lg_wd [256];
  int rv_cyc [256]; int rv_dat [256];
  logic [3:0] mrow [4];
  logic [7:0] mem [1024];
  logic rq_vld [16]; logic [7:0] rq_dat [16];

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    for (int i = 0; i < 16; i++) begin rq_vld[i] = 1'b0; rq_dat[i] = 8'h00; end
    for (int i = 0; i < 4; i++) mrow[i] = 4'h0;
  end

  always @(posedge clk) cyc <= cyc + 1;

  // bank model: returns read data CL cycles after a read command
  always @(posedge clk) begin
    #1;
    if (rq_vld[cyc % 16]) begin
      dram_rdata = rq_dat[cyc % 16];
      rq_vld[cyc % 16] = 1'b0;
    end else dram_rdata = 8'h00;
  end

  always @(negedge clk) begin
    if (rst_n && cmd_code != 3'd0) begin
      lg_cyc[log_n] = cyc; lg_code[log_n] = cmd_code; lg_bank[log_n] = cmd_bank;
      lg_addr[log_n] = cmd_addr; lg_wd[log_n] = cmd_wdata; log_n++;
      if (cmd_code == 3'd1) mrow[cmd_bank] = cmd_addr;
      if (cmd_code == 3'd3) mem[{mrow[cmd_bank], cmd_bank, cmd_addr}] = cmd_wdata;
      if (cmd_code == 3'd2) begin
        rq_vld[(cyc + CL) % 16] = 1'b1;
        rq_dat[(cyc + CL) % 16] = mem[{mrow[cmd_bank], cmd_bank, cmd_addr}];
      end
    end
    if (rst_n && rd_valid) begin rv_cyc[rv_n] = cyc; rv_dat[rv_n] = rd_data; rv_n++; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input int row, input int bank, input int col,
                        input int data, output int first);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_addr = {row[3:0], bank[1:0], col[3:0]}; req_wdata = data[7:0];
    first = log_n;
    @(negedge clk);
    req_valid = 1'b0;
    do begin @(negedge clk); #1; end
    while (!(log_n > first && (lg_code[log_n-1] == 2 || lg_code[log_n-1] == 3)));
  endtask

  task automatic exp_cmd(input int i, input int code, input int bank, input int addr, input string tag);
    chk(lg_code[i] == code, {tag, " code"}, lg_code[i], code);
    chk(lg_bank[i] == bank, {tag, " bank"}, lg_bank[i], bank);
    if (code != 4) chk(lg_addr[i] == addr, {tag, " addr"}, lg_addr[i], addr);
  endtask

  task automatic chk_ready_r7(input string tag);
    for (int k = 1; k < T_CCD - 1; k++) begin
      @(negedge clk); #1;
      chk(req_ready == 1'b0, {tag, " R7 ready low after column"}, req_ready, 0);
    end
    @(negedge clk); #1;
    chk(req_ready == 1'b1, {tag, " R7 ready back"}, req_ready, 1);
  endtask

  task automatic chk_rdata_r8(input int ccyc, input int exp, input string tag);
    int hits = 0, val = -1;
    repeat (CL + 1) @(negedge clk);
    #1;
    for (int i = 0; i < rv_n; i++) if (rv_cyc[i] == ccyc + CL) begin hits++; val = rv_dat[i]; end
    chk(hits == 1, {tag, " R8 rd_valid at CL"}, hits, 1);
    chk(val == exp, {tag, " R8 rd_data"}, val, exp);
  endtask

  task automatic t_reset;
    #1;
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(cmd_code == 3'd0, "R1 cmd idle after reset", cmd_code, 0);
    chk(rd_valid == 1'b0, "R1 rd_valid low after reset", rd_valid, 0);
  endtask

  task automatic t_closed_write;
    int f;
    do_req(1'b1, 5, 0, 3, 8'hA5, f);
    chk(log_n - f == 2, "R5 closed bank: two commands", log_n - f, 2);
    exp_cmd(f, 1, 0, 5, "R2 R5 activate with row");
    exp_cmd(f + 1, 3, 0, 3, "R2 R5 write with column");
    chk(lg_wd[f + 1] == 8'hA5, "R8 write data with command", lg_wd[f + 1], 8'hA5);
    chk(lg_cyc[f + 1] - lg_cyc[f] == T_RCD, "R6 activate to column", lg_cyc[f + 1] - lg_cyc[f], T_RCD);
    chk_ready_r7("closed write");
  endtask

  task automatic t_hit_read;
    int f;
    do_req(1'b0, 5, 0, 3, 0, f);
    chk(log_n - f == 1, "R3 row hit: one command", log_n - f, 1);
    exp_cmd(f, 2, 0, 3, "R3 read column");
    chk_ready_r7("hit read");
    chk_rdata_r8(lg_cyc[f], 8'hA5, "hit read");
  endtask

  task automatic t_miss_write;
    int f;
    do_req(1'b1, 9, 0, 7, 8'h3C, f);
    chk(log_n - f == 3, "R4 row miss: three commands", log_n - f, 3);
    exp_cmd(f, 4, 0, 0, "R4 precharge first");
    exp_cmd(f + 1, 1, 0, 9, "R4 activate new row");
    exp_cmd(f + 2, 3, 0, 7, "R4 write column");
    chk(lg_cyc[f + 1] - lg_cyc[f] == T_RP, "R6 precharge to activate", lg_cyc[f + 1] - lg_cyc[f], T_RP);
    chk(lg_cyc[f + 2] - lg_cyc[f + 1] == T_RCD, "R6 activate to column (miss)", lg_cyc[f + 2] - lg_cyc[f + 1], T_RCD);
    chk(f == 0 || lg_cyc[f] - lg_cyc[f - 1] >= T_CCD, "R6 column to next command", lg_cyc[f] - lg_cyc[f - 1], T_CCD);
  endtask

  task automatic t_two_banks;
    int f;
    do_req(1'b1, 1, 2, 0, 8'h77, f);
    chk(log_n - f == 2, "R9 R5 other bank opens without precharge", log_n - f, 2);
    exp_cmd(f, 1, 2, 1, "R9 activate bank 2");
    do_req(1'b0, 9, 0, 7, 0, f);
    chk(log_n - f == 1, "R9 bank 0 row still open", log_n - f, 1);
    exp_cmd(f, 2, 0, 7, "R9 read bank 0");
    chk_rdata_r8(lg_cyc[f], 8'h3C, "bank 0 after bank 2");
  endtask

  task automatic t_reopen_read;
    int f;
    do_req(1'b0, 5, 0, 3, 0, f);
    chk(log_n - f == 3, "R4 reopen old row: three commands", log_n - f, 3);
    exp_cmd(f + 1, 1, 0, 5, "R4 reactivate row 5");
    chk_rdata_r8(lg_cyc[f + 2], 8'hA5, "reopened row");
    do_req(1'b0, 1, 2, 0, 0, f);
    chk(log_n - f == 1, "R9 bank 2 row kept", log_n - f, 1);
    chk_rdata_r8(lg_cyc[f], 8'h77, "bank 2 read");
  endtask

  task automatic t_edge_addr;
    int f;
    do_req(1'b1, 15, 3, 15, 8'hFF, f);
    exp_cmd(f, 1, 3, 15, "R2 top row in top bank");
    exp_cmd(f + 1, 3, 3, 15, "R2 top column");
    do_req(1'b0, 15, 3, 15, 0, f);
    chk(log_n - f == 1, "R3 hit at top address", log_n - f, 1);
    chk_rdata_r8(lg_cyc[f], 8'hFF, "top address");
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_closed_write;
        t_hit_read;
        t_miss_write;
        t_two_banks;
        t_reopen_read;
        t_edge_addr;
        repeat (4) @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule